// File: doc/BRIEF.md
# Partitioned 8x16 Multiply Unit

This block is a SIMD multiplier for pixel arithmetic. It multiplies unsigned 8-bit pixel components by signed 16-bit coefficients in parallel lanes. Each signed product is 24 bits wide. The block keeps the middle 16 bits of each product and rounds half up using the bit just below them. A 3-bit mode selects where the factors and coefficients come from. In the lane-wise mode every lane has its own coefficient. In the two alpha modes one coefficient is shared by all four lanes. In the byte modes the factor is the upper or the lower byte of each 16-bit lane. The two wide modes form only two products and place each one at a shifted position inside a 32-bit half of the result.

The caller presents two 64-bit operands, a mode and a valid strobe. The 64-bit result and its valid flag appear one clock later from a single register stage. The result register holds its value until the next valid input, so a consumer may read it at any later time. Register files and instruction decode lie outside the block.

Top module: `pmul8x16_unit`

## Requirements
- R1: Mode 0 (lane-wise): for each lane i in 0..3, the factor is `opa[8i+7:8i]` and the coefficient is `opb[16i+15:16i]`; the scaled product goes to `result[16i+15:16i]`.
- R2: Scaling: each factor is unsigned and each coefficient is signed two's complement. The 24-bit signed product p gives the lane value p[23:8] + p[7], taken modulo 2^16.
- R3: Modes 1 and 2 (alpha): the factor of lane i is `opa[8i+7:8i]`. One coefficient is used by all four lanes: `opb[31:16]` in mode 1 and `opb[15:0]` in mode 2. Lane i goes to `result[16i+15:16i]`.
- R4: Modes 3 and 4 (byte select): the factor of lane i is `opa[16i+15:16i+8]` in mode 3 and `opa[16i+7:16i]` in mode 4. The coefficient is `opb[16i+15:16i]`, and lane i goes to `result[16i+15:16i]`.
- R5: Modes 5 and 6 (wide): only lanes 0 and 1 are formed. The factor is `opa[16i+15:16i+8]` in mode 5 and `opa[16i+7:16i]` in mode 6, and the coefficient is `opb[16i+15:16i]`. Each 16-bit value goes to `result[32i+22:32i+7]`, and every other result bit is 0.
- R6: When a rounding increment overflows a lane's 16 bits, the lane wraps to 0x0000 and no carry reaches the neighbouring lane.
- R7: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. The result of that input is present in that same cycle.
- R8: While `in_valid` is low, `result` keeps its value whatever `opa`, `opb` and `mode` do.
- R9: Mode 7 is reserved and produces an all-zero result.
- R10: After reset, `out_valid` is 0 and `result` is 0.
- R11: Operand bits that the selected mode does not name have no effect on the result, for example `opa[63:32]` in modes 0, 1, 2, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 3 | Variant select, codes 0 to 7 as in R1 to R9 |
| opa | input | 64 | Unsigned 8-bit factor source |
| opb | input | 64 | Signed 16-bit coefficient source |
| out_valid | output | 1 | Result of the previous valid input is present |
| result | output | 64 | Registered partitioned product |

## Verification
Two things can happen in the same cycle. One lane's rounding increment can overflow and wrap, while its neighbours produce large ordinary products. A carry that leaked out of the wrapping lane would show up as an off-by-one value in the lane above. The bench provokes this with a factor of 1 and a coefficient of -1 in alternate lanes, which wrap. The lanes between them use a factor of 255 and a coefficient of 0x7FFF. Every lane is then compared exactly against an integer model. The lane-wise sweep puts all 256 factor values against boundary coefficients in lane 0 while the other lanes carry unrelated values, so the same coincidence recurs across the whole range.

// File: rtl/pmul8x16_pkg.sv
package pmul8x16_pkg;

  localparam int PM_LANES   = 4;
  localparam int PM_FACT_W  = 8;
  localparam int PM_COEF_W  = 16;
  localparam int PM_PROD_W  = PM_FACT_W + PM_COEF_W;
  localparam int PM_WORD_W  = PM_LANES * PM_COEF_W;
  localparam int PM_WIDE_N  = PM_LANES / 2;
  localparam int PM_WIDE_ST = PM_WORD_W / PM_WIDE_N;
  localparam int PM_WIDE_OF = 7;

  typedef enum logic [2:0] {
    PM_LANE     = 3'd0,
    PM_ALPHA_HI = 3'd1,
    PM_ALPHA_LO = 3'd2,
    PM_BYTE_HI  = 3'd3,
    PM_BYTE_LO  = 3'd4,
    PM_WIDE_HI  = 3'd5,
    PM_WIDE_LO  = 3'd6,
    PM_RSVD     = 3'd7
  } pm_mode_e;

  // Unsigned factor times signed coefficient, full signed product.
  function automatic logic [PM_PROD_W-1:0] pm_product(
    input logic [PM_FACT_W-1:0] f,
    input logic [PM_COEF_W-1:0] c
  );
    logic signed [PM_PROD_W:0] p;
    p = $signed({1'b0, f}) * $signed(c);
    return p[PM_PROD_W-1:0];
  endfunction

  // Drop the low byte and round half up; the sum wraps inside 16 bits.
  function automatic logic [PM_COEF_W-1:0] pm_scale(input logic [PM_PROD_W-1:0] p);
    return p[PM_PROD_W-1:PM_FACT_W] + {{(PM_COEF_W-1){1'b0}}, p[PM_FACT_W-1]};
  endfunction

  // True when the rounding increment overflows the lane.
  function automatic logic pm_wraps(input logic [PM_PROD_W-1:0] p);
    return p[PM_FACT_W-1] & (&p[PM_PROD_W-1:PM_FACT_W]);
  endfunction

endpackage

// File: rtl/pmul8x16_opsel.sv
module pmul8x16_opsel
  import pmul8x16_pkg::*;
(
  input  pm_mode_e                              mode,
  input  logic [PM_WORD_W-1:0]                  opa,
  input  logic [PM_WORD_W-1:0]                  opb,
  output logic [PM_LANES-1:0][PM_FACT_W-1:0]    fact,
  output logic [PM_LANES-1:0][PM_COEF_W-1:0]    coef
);

  localparam int HALF_W = PM_WORD_W / 2;

  for (genvar i = 0; i < PM_LANES; i++) begin : g_sel
    always_comb begin
      fact[i] = '0;
      coef[i] = '0;
      case (mode)
        PM_LANE: begin
          fact[i] = opa[PM_FACT_W*i +: PM_FACT_W];
          coef[i] = opb[PM_COEF_W*i +: PM_COEF_W];
        end
        PM_ALPHA_HI: begin
          fact[i] = opa[PM_FACT_W*i +: PM_FACT_W];
          coef[i] = opb[HALF_W-1 -: PM_COEF_W];
        end
        PM_ALPHA_LO: begin
          fact[i] = opa[PM_FACT_W*i +: PM_FACT_W];
          coef[i] = opb[PM_COEF_W-1:0];
        end
        PM_BYTE_HI, PM_WIDE_HI: begin
          fact[i] = opa[PM_COEF_W*i + PM_FACT_W +: PM_FACT_W];
          coef[i] = opb[PM_COEF_W*i +: PM_COEF_W];
        end
        PM_BYTE_LO, PM_WIDE_LO: begin
          fact[i] = opa[PM_COEF_W*i +: PM_FACT_W];
          coef[i] = opb[PM_COEF_W*i +: PM_COEF_W];
        end
        default: begin
          fact[i] = '0;
          coef[i] = '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/pmul8x16_lane.sv
module pmul8x16_lane
  import pmul8x16_pkg::*;
(
  input  logic [PM_FACT_W-1:0] fact,
  input  logic [PM_COEF_W-1:0] coef,
  output logic [PM_COEF_W-1:0] scaled,
  output logic                 wrap
);

  logic [PM_PROD_W-1:0] prod;

  assign prod   = pm_product(fact, coef);
  assign scaled = pm_scale(prod);
  assign wrap   = pm_wraps(prod);

endmodule

// File: rtl/pmul8x16_pack.sv
module pmul8x16_pack
  import pmul8x16_pkg::*;
(
  input  pm_mode_e                           mode,
  input  logic [PM_LANES-1:0][PM_COEF_W-1:0] scaled,
  output logic [PM_WORD_W-1:0]               word
);

  always_comb begin
    word = '0;
    case (mode)
      PM_LANE, PM_ALPHA_HI, PM_ALPHA_LO, PM_BYTE_HI, PM_BYTE_LO: begin
        for (int i = 0; i < PM_LANES; i++) begin
          word[PM_COEF_W*i +: PM_COEF_W] = scaled[i];
        end
      end
      PM_WIDE_HI, PM_WIDE_LO: begin
        for (int i = 0; i < PM_WIDE_N; i++) begin
          word[PM_WIDE_ST*i + PM_WIDE_OF +: PM_COEF_W] = scaled[i];
        end
      end
      default: word = '0;
    endcase
  end

endmodule

// File: rtl/pmul8x16_unit.sv
module pmul8x16_unit
  import pmul8x16_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  mode,
  input  logic [63:0] opa,
  input  logic [63:0] opb,
  output logic        out_valid,
  output logic [63:0] result
);

  pm_mode_e                           mode_e;
  logic [PM_LANES-1:0][PM_FACT_W-1:0] fact;
  logic [PM_LANES-1:0][PM_COEF_W-1:0] coef;
  logic [PM_LANES-1:0][PM_COEF_W-1:0] scaled;
  logic [PM_LANES-1:0]                lane_wrap;
  logic [PM_WORD_W-1:0]               next_word;

  assign mode_e = pm_mode_e'(mode);

  pmul8x16_opsel u_opsel (
    .mode (mode_e),
    .opa  (opa),
    .opb  (opb),
    .fact (fact),
    .coef (coef)
  );

  for (genvar i = 0; i < PM_LANES; i++) begin : g_lane
    pmul8x16_lane u_lane (
      .fact   (fact[i]),
      .coef   (coef[i]),
      .scaled (scaled[i]),
      .wrap   (lane_wrap[i])
    );
  end

  pmul8x16_pack u_pack (
    .mode   (mode_e),
    .scaled (scaled),
    .word   (next_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= next_word;
      end
    end
  end

endmodule

module pmul8x16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  mode,
  input logic        out_valid,
  input logic [63:0] result,
  input logic [3:0]  lane_wrap
);

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd7) |=> (result == 64'h0));

  // R5
  wide_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == 3'd5 || mode == 3'd6)) |=>
      (result[6:0] == 7'h0 && result[38:23] == 16'h0 && result[63:55] == 9'h0));

  for (genvar i = 0; i < 4; i++) begin : g_wrap
    // R6
    lane_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode <= 3'd4 && lane_wrap[i]) |=> (result[16*i +: 16] == 16'h0));
  end

endmodule

bind pmul8x16_unit pmul8x16_chk u_pmul8x16_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .mode      (mode),
  .out_valid (out_valid),
  .result    (result),
  .lane_wrap (lane_wrap)
);

// File: tb/pmul8x16_unit_bench.sv
module pmul8x16_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic        out_valid;
  logic [63:0] result;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  pmul8x16_unit u_pmul8x16_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .opa       (opa),
    .opb       (opb),
    .out_valid (out_valid),
    .result    (result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errs++;
      $display("FAIL R7 watchdog expired act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  // Integer restatement of the scaling rule (R2).
  function automatic logic [15:0] ref_scale(int f, int c);
    int p;
    int r;
    p = f * c;
    r = (p >>> 8) + ((p >>> 7) & 1);
    return r[15:0];
  endfunction

  function automatic logic [63:0] ref_model(logic [2:0] m, logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    int f;
    int c;
    r = '0;
    case (m)
      3'd0, 3'd1, 3'd2, 3'd3, 3'd4: begin
        for (int i = 0; i < 4; i++) begin
          if (m == 3'd3)      f = int'(a[16*i+8 +: 8]);
          else if (m == 3'd4) f = int'(a[16*i +: 8]);
          else                f = int'(a[8*i +: 8]);
          if (m == 3'd1)      c = $signed(b[31:16]);
          else if (m == 3'd2) c = $signed(b[15:0]);
          else                c = $signed(b[16*i +: 16]);
          r[16*i +: 16] = ref_scale(f, c);
        end
      end
      3'd5, 3'd6: begin
        for (int i = 0; i < 2; i++) begin
          f = (m == 3'd5) ? int'(a[16*i+8 +: 8]) : int'(a[16*i +: 8]);
          c = $signed(b[16*i +: 16]);
          r = r | (64'(ref_scale(f, c)) << (32*i + 7));
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check1(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic run_op(string tag, logic [2:0] m, logic [63:0] a, logic [63:0] b,
                        logic [63:0] exp);
    @(negedge clk);
    mode = m;
    opa = a;
    opb = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check1({tag, " R7 out_valid"}, out_valid, 1'b1);
    check64(tag, result, exp);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    logic [15:0] edge_c [8];
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] held;
    edge_c = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
               16'h8000, 16'h0080, 16'hFF80, 16'hFF7F};

    repeat (3) @(negedge clk);
    // R10: reset state
    check1("R10 out_valid at reset", out_valid, 1'b0);
    check64("R10 result at reset", result, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check1("R10 out_valid after release", out_valid, 1'b0);
    check64("R10 result after release", result, 64'h0);

    // R2: rounding on product bit 7
    run_op("R2 rounding", 3'd0, 64'h0000_0000_0101_0101,
           64'h0080_007F_0180_017F, 64'h0001_0000_0002_0001);

    // R6: wrapped lanes beside large products, no carry leak
    run_op("R6 wrap isolation", 3'd0, 64'h0000_0000_FF01_FF01,
           64'h7FFF_FFFF_7FFF_FFFF, 64'h7F7F_0000_7F7F_0000);

    // R5: wide placement at bit 32*i+7
    run_op("R5 wide placement", 3'd5, 64'h0000_0000_0200_0100,
           64'h0000_0000_0100_0100, 64'h0000_0100_0000_0080);

    // R1 with R2: all factor values against boundary coefficients, junk in upper opa (R11)
    for (int f = 0; f < 256; f++) begin
      for (int k = 0; k < 64; k++) begin
        a = {$urandom, 8'(f + 3*k), 8'(~f), 8'(f ^ k), 8'(f)};
        b = {$urandom, 16'($urandom), edge_c[k % 8]};
        run_op("R1 lane-wise sweep", 3'd0, a, b, ref_model(3'd0, a, b));
      end
    end

    // R3, R4, R5 and R11 with random operands
    for (int m = 1; m <= 6; m++) begin
      for (int n = 0; n < 1500; n++) begin
        a = rnd64();
        b = rnd64();
        if (n % 4 == 0) b[15:0] = edge_c[n % 8];
        if (m <= 2)      run_op("R3 alpha mode", 3'(m), a, b, ref_model(3'(m), a, b));
        else if (m <= 4) run_op("R4 byte mode", 3'(m), a, b, ref_model(3'(m), a, b));
        else             run_op("R5 R11 wide mode", 3'(m), a, b, ref_model(3'(m), a, b));
      end
    end

    // R9: reserved code
    for (int n = 0; n < 50; n++) begin
      run_op("R9 reserved mode", 3'd7, rnd64(), rnd64(), 64'h0);
    end

    // R8: hold while idle
    a = 64'h0000_0000_1234_5678;
    b = 64'h0000_0000_9ABC_DEF0;
    held = ref_model(3'd0, a, b);
    run_op("R8 setup", 3'd0, a, b, held);
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      mode = 3'($urandom);
      opa = rnd64();
      opb = rnd64();
      @(negedge clk);
      check64("R8 hold while idle", result, held);
      check1("R7 idle out_valid", out_valid, 1'b0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule